// File: doc/BRIEF.md
# Extended Display Register Access Unit

This block is the host-facing register file of a VGA-class display controller that has extended registers. A host drives an 8-bit I/O bus with a 16-bit port address and separate read and write strobes. The block decodes the indexed sequencer and CRT controller port pairs, the single-port attribute controller with its index/data toggle, and a relocatable video subsystem enable register. It holds the stored values and exports the extended ones to the rest of the controller.

The extended registers stay locked after reset. The host unlocks them by writing a two-step key, first to the display-mode port and then to the mode-control port. While the lock holds, writes to extended registers are dropped and reads of them return zero. One extended CRT register, the overflow register at index 0x35, has a further guard: a protect bit in the standard CRT register 0x11 blocks writes to it.

Read data is combinational. It is valid during the cycle in which the read strobe is high and reflects the state before any write in that same cycle. All state changes occur on the rising clock edge.

Top module: `xreg_host_port`

## Requirements
- R1: On synchronous active-high reset, every register, index and the attribute toggle clear to zero and the extensions are locked. Reads of any mapped port then return 0x00.
- R2: Writing 0x03 to port 0x3BF, with the next write being 0xA0 to port 0x3D8, unlocks the extensions from the following cycle. The unlock holds until reset. Reads between the two key writes do not disturb the sequence.
- R3: After the first key write, any other write restarts detection. This includes a write to a different port and a write of a wrong value to 0x3D8. A following 0xA0 to 0x3D8 then leaves the extensions locked.
- R4: The extended registers are CRT indices 0x30–0x37 and 0x3F, sequencer index 0x07 and attribute index 0x16. While locked, writes to them are dropped and reads of them return 0x00.
- R5: The sequencer index is written at 0x3C4 and read back there. Its data is written and read at 0x3C5 for indices 0x00–0x07. The stored byte of index 0x07 is exported.
- R6: The CRT index is written at 0x3D4 and read back there. Data is written and read at 0x3D5 for standard indices 0x00–0x18 and for the extended indices.
- R7: A write to CRT index 0x35 is ignored while bit 7 of CRT index 0x11 is 1. The write takes effect once that bit is 0.
- R8: Writes to port 0x3C0 alternate between index and data, starting with index. A read at 0x3C0 returns the last index. A read at 0x3C1 returns the data stored at that index, for indices 0x00–0x16. The byte of index 0x16 is exported.
- R9: A read of port 0x3DA returns 0x00 and returns the attribute toggle to the index phase.
- R10: Bit 3 of CRT index 0x34 places the video subsystem enable register at port 0x46E8 when set and at 0x3C3 when clear. At the port not selected, reads return 0x00 and writes are ignored.
- R11: The extended CRT bytes are exported in the order 0x30 through 0x37 in bytes 0–7, and 0x3F in byte 8. Bits 1:0 of index 0x33 are exported as display start bits 17:16, and bits 3:2 as cursor start bits 17:16.
- R12: Data writes at unmapped indices (CRT 0x19–0x2F and 0x38–0x3E, sequencer above 0x07) change nothing, and reads there return 0x00.
- R13: When the read and write strobes are high in the same cycle at one port, the read returns the state before the write, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero when no read is strobed |
| unlocked_o | output | 1 | Extensions unlocked |
| crt_ext_o | output | 72 | Extended CRT bytes, 0x30..0x37 then 0x3F |
| seq_ext_o | output | 8 | Extended sequencer byte (index 0x07) |
| att_ext_o | output | 8 | Extended attribute byte (index 0x16) |
| vse_o | output | 8 | Video subsystem enable register |
| vse_alt_o | output | 1 | Enable register mapped at 0x46E8 |
| start_hi_o | output | 2 | Display start address bits 17:16 |
| cursor_hi_o | output | 2 | Cursor start address bits 17:16 |

## Verification
The bus has a single address, so the only two functions that can meet in one cycle are a read and a write strobed together at the same port. The sharpest case is the attribute port in its data phase, where the read must return the old index while the write lands as data and flips the toggle. The bench drives both strobes in one cycle at 0x3C0 and samples the read data before the edge. It then judges the outcome through a later read at 0x3C1 and a fresh index write, which must be taken as an index.

// File: rtl/xrp_pkg.sv
package xrp_pkg;
  localparam int DW    = 8;
  localparam int AW    = 16;
  localparam int IDX_W = 8;

  localparam logic [AW-1:0] P_KEY1    = 16'h03BF;
  localparam logic [AW-1:0] P_KEY2    = 16'h03D8;
  localparam logic [AW-1:0] P_ATT     = 16'h03C0;
  localparam logic [AW-1:0] P_ATT_RD  = 16'h03C1;
  localparam logic [AW-1:0] P_VSE_STD = 16'h03C3;
  localparam logic [AW-1:0] P_SEQ_IDX = 16'h03C4;
  localparam logic [AW-1:0] P_SEQ_DAT = 16'h03C5;
  localparam logic [AW-1:0] P_CRT_IDX = 16'h03D4;
  localparam logic [AW-1:0] P_CRT_DAT = 16'h03D5;
  localparam logic [AW-1:0] P_STATUS  = 16'h03DA;
  localparam logic [AW-1:0] P_VSE_ALT = 16'h46E8;

  localparam logic [DW-1:0] KEY1_VAL = 8'h03;
  localparam logic [DW-1:0] KEY2_VAL = 8'hA0;

  localparam int SEQ_N       = 8;
  localparam int SEQ_EXT_IDX = 7;
  localparam int CRT_STD_N   = 25;
  localparam int CRT_EXT_N   = 9;
  localparam int ATT_N       = 23;
  localparam int ATT_EXT_IDX = 22;

  localparam int CRT_PROT_REG  = 17;
  localparam int CRT_PROT_BIT  = 7;
  localparam int CRT_GUARD_SLT = 5;
  localparam int CRT_VSE_SLT   = 4;
  localparam int CRT_VSE_BIT   = 3;
  localparam int CRT_START_SLT = 3;

  localparam logic [3:0] NO_SLOT = 4'hF;

  // Maps a CRT index onto an extended storage slot, or NO_SLOT.
  function automatic logic [3:0] crt_ext_slot(input logic [IDX_W-1:0] i);
    if (i[7:3] == 5'b00110) return {1'b0, i[2:0]};
    if (i == 8'h3F)         return 4'd8;
    return NO_SLOT;
  endfunction
endpackage

// File: rtl/xrp_regbank.sv
module xrp_regbank #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int IW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IW-1:0]   idx,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [N*DW-1:0] flat
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                         q <= '0;
      else if (we && int'(idx) == g)   q <= wdata;
    end
    assign flat[g*DW +: DW] = q;
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < N; k++)
      if (int'(idx) == k) rdata = flat[k*DW +: DW];
  end
endmodule

// File: rtl/xrp_unlock.sv
module xrp_unlock
  import xrp_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          armed,
  output logic          key_hit,
  output logic          unlocked
);
  logic first_key;
  assign first_key = wr && addr == P_KEY1 && wdata == KEY1_VAL;
  assign key_hit   = wr && armed && addr == P_KEY2 && wdata == KEY2_VAL;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      unlocked <= 1'b0;
    end else begin
      if (wr)      armed    <= first_key;
      if (key_hit) unlocked <= 1'b1;
    end
  end
endmodule

// File: rtl/xrp_attr.sv
module xrp_attr
  import xrp_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          unlocked,
  input  logic          wr,
  input  logic          stat_rd,
  input  logic [DW-1:0] wdata,
  output logic          phase,
  output logic [DW-1:0] idx_q,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] ext_o
);
  logic              is_ext, data_we;
  logic [DW-1:0]     bank_rd;
  logic [ATT_N*DW-1:0] flat;
  logic              unused_att;

  assign is_ext  = int'(idx_q) == ATT_EXT_IDX;
  assign data_we = wr && phase && (!is_ext || unlocked);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      idx_q <= '0;
    end else begin
      if (wr && !phase) idx_q <= wdata;
      if (stat_rd)      phase <= 1'b0;
      else if (wr)      phase <= ~phase;
    end
  end

  xrp_regbank #(.N(ATT_N), .DW(DW), .IW(DW)) i_bank (
    .clk(clk), .rst(rst), .we(data_we), .idx(idx_q), .wdata(wdata),
    .rdata(bank_rd), .flat(flat)
  );

  assign rdata      = (is_ext && !unlocked) ? '0 : bank_rd;
  assign ext_o      = flat[ATT_EXT_IDX*DW +: DW];
  assign unused_att = ^flat[ATT_EXT_IDX*DW-1:0];
endmodule

// File: rtl/xreg_host_port.sv
module xreg_host_port
  import xrp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [AW-1:0]         io_addr,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [DW-1:0]         io_wdata,
  output logic [DW-1:0]         io_rdata,
  output logic                  unlocked_o,
  output logic [CRT_EXT_N*DW-1:0] crt_ext_o,
  output logic [DW-1:0]         seq_ext_o,
  output logic [DW-1:0]         att_ext_o,
  output logic [DW-1:0]         vse_o,
  output logic                  vse_alt_o,
  output logic [1:0]            start_hi_o,
  output logic [1:0]            cursor_hi_o
);
  logic          key_armed, key_hit;
  logic [DW-1:0] seq_idx_q, crt_idx_q, vse_q;
  logic          seq_is_ext, seq_we;
  logic [DW-1:0] seq_bank_rd, seq_rd;
  logic [SEQ_N*DW-1:0] seq_flat;
  logic [3:0]    crt_slot;
  logic          crt_dat_wr, crt_guard_on, crt35_wr_blocked, crt_ext_we;
  logic [DW-1:0] crt_std_rd, crt_ext_rd, crt_rd;
  logic [CRT_STD_N*DW-1:0] crt_std_flat;
  logic          att_phase;
  logic [DW-1:0] att_idx, att_rd;
  logic          vse_we;
  logic [DW-1:0] rd_mux;
  logic          unused_bits;

  xrp_unlock i_unlock (
    .clk(clk), .rst(rst), .wr(io_wr), .addr(io_addr), .wdata(io_wdata),
    .armed(key_armed), .key_hit(key_hit), .unlocked(unlocked_o)
  );

  // Index registers for the two indexed port pairs.
  always_ff @(posedge clk) begin
    if (rst) begin
      seq_idx_q <= '0;
      crt_idx_q <= '0;
    end else if (io_wr) begin
      if (io_addr == P_SEQ_IDX) seq_idx_q <= io_wdata;
      if (io_addr == P_CRT_IDX) crt_idx_q <= io_wdata;
    end
  end

  // Sequencer
  assign seq_is_ext = int'(seq_idx_q) == SEQ_EXT_IDX;
  assign seq_we     = io_wr && io_addr == P_SEQ_DAT && (!seq_is_ext || unlocked_o);

  xrp_regbank #(.N(SEQ_N), .DW(DW), .IW(IDX_W)) i_seq (
    .clk(clk), .rst(rst), .we(seq_we), .idx(seq_idx_q), .wdata(io_wdata),
    .rdata(seq_bank_rd), .flat(seq_flat)
  );
  assign seq_rd    = (seq_is_ext && !unlocked_o) ? '0 : seq_bank_rd;
  assign seq_ext_o = seq_flat[SEQ_EXT_IDX*DW +: DW];

  // CRT controller: standard bank plus extended bank with guard on 0x35.
  assign crt_slot   = crt_ext_slot(crt_idx_q);
  assign crt_dat_wr = io_wr && io_addr == P_CRT_DAT;

  xrp_regbank #(.N(CRT_STD_N), .DW(DW), .IW(IDX_W)) i_crt_std (
    .clk(clk), .rst(rst), .we(crt_dat_wr), .idx(crt_idx_q), .wdata(io_wdata),
    .rdata(crt_std_rd), .flat(crt_std_flat)
  );

  assign crt_guard_on     = crt_std_flat[CRT_PROT_REG*DW + CRT_PROT_BIT];
  assign crt35_wr_blocked = crt_dat_wr && unlocked_o && crt_guard_on
                            && int'(crt_slot) == CRT_GUARD_SLT;
  assign crt_ext_we       = crt_dat_wr && unlocked_o && crt_slot != NO_SLOT
                            && !crt35_wr_blocked;

  xrp_regbank #(.N(CRT_EXT_N), .DW(DW), .IW(4)) i_crt_ext (
    .clk(clk), .rst(rst), .we(crt_ext_we), .idx(crt_slot), .wdata(io_wdata),
    .rdata(crt_ext_rd), .flat(crt_ext_o)
  );

  assign crt_rd = (crt_slot == NO_SLOT) ? crt_std_rd
                : (unlocked_o ? crt_ext_rd : '0);

  assign start_hi_o  = crt_ext_o[CRT_START_SLT*DW +: 2];
  assign cursor_hi_o = crt_ext_o[CRT_START_SLT*DW + 2 +: 2];
  assign vse_alt_o   = crt_ext_o[CRT_VSE_SLT*DW + CRT_VSE_BIT];

  // Attribute controller
  xrp_attr i_attr (
    .clk(clk), .rst(rst), .unlocked(unlocked_o),
    .wr(io_wr && io_addr == P_ATT), .stat_rd(io_rd && io_addr == P_STATUS),
    .wdata(io_wdata), .phase(att_phase), .idx_q(att_idx),
    .rdata(att_rd), .ext_o(att_ext_o)
  );

  // Relocatable video subsystem enable register
  assign vse_we = io_wr && (vse_alt_o ? io_addr == P_VSE_ALT : io_addr == P_VSE_STD);
  always_ff @(posedge clk) begin
    if (rst)         vse_q <= '0;
    else if (vse_we) vse_q <= io_wdata;
  end
  assign vse_o = vse_q;

  // Read multiplexer
  always_comb begin
    unique case (io_addr)
      P_SEQ_IDX: rd_mux = seq_idx_q;
      P_SEQ_DAT: rd_mux = seq_rd;
      P_CRT_IDX: rd_mux = crt_idx_q;
      P_CRT_DAT: rd_mux = crt_rd;
      P_ATT:     rd_mux = att_idx;
      P_ATT_RD:  rd_mux = att_rd;
      P_VSE_STD: rd_mux = vse_alt_o ? '0 : vse_q;
      P_VSE_ALT: rd_mux = vse_alt_o ? vse_q : '0;
      default:   rd_mux = '0;
    endcase
  end
  assign io_rdata = io_rd ? rd_mux : '0;

  assign unused_bits = ^{seq_flat[SEQ_EXT_IDX*DW-1:0], crt_std_flat, key_armed,
                         key_hit, att_phase};
endmodule

// File: rtl/xrp_chk.sv
module xrp_chk
  import xrp_pkg::*;
(
  input logic                   clk,
  input logic                   rst,
  input logic [AW-1:0]          io_addr,
  input logic                   io_wr,
  input logic                   io_rd,
  input logic [DW-1:0]          io_wdata,
  input logic [DW-1:0]          io_rdata,
  input logic                   unlocked_o,
  input logic [CRT_EXT_N*DW-1:0] crt_ext_o,
  input logic [DW-1:0]          crt_idx_q,
  input logic                   att_phase,
  input logic                   crt35_wr_blocked
);
  // R2
  unlock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    unlocked_o |=> unlocked_o);

  // R2
  unlock_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked_o) |-> $past(io_wr && io_addr == P_KEY2 && io_wdata == KEY2_VAL));

  // R4
  locked_read_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !unlocked_o && io_addr == P_CRT_DAT &&
     (crt_idx_q[7:4] == 4'h3)) |-> io_rdata == 8'h00);

  // R7
  crt35_guard_chk: assert property (@(posedge clk) disable iff (rst)
    crt35_wr_blocked |=> $stable(crt_ext_o[CRT_GUARD_SLT*DW +: DW]));

  // R9
  att_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == P_STATUS) |=> !att_phase);

  // R8
  att_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == P_ATT) |=> att_phase != $past(att_phase));
endmodule

bind xreg_host_port xrp_chk i_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .unlocked_o(unlocked_o),
  .crt_ext_o(crt_ext_o), .crt_idx_q(crt_idx_q), .att_phase(att_phase),
  .crt35_wr_blocked(crt35_wr_blocked)
);

// File: tb/test_xreg_host_port.sv
`timescale 1ns/1ps
module test_xreg_host_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        unlocked_o, vse_alt_o;
  logic [71:0] crt_ext_o;
  logic [7:0]  seq_ext_o, att_ext_o, vse_o;
  logic [1:0]  start_hi_o, cursor_hi_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xreg_host_port i_xreg_host_port (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .unlocked_o(unlocked_o),
    .crt_ext_o(crt_ext_o), .seq_ext_o(seq_ext_o), .att_ext_o(att_ext_o),
    .vse_o(vse_o), .vse_alt_o(vse_alt_o), .start_hi_o(start_hi_o),
    .cursor_hi_o(cursor_hi_o)
  );

  task automatic chk(input string tag, input logic [71:0] got, input logic [71:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] v;
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1 v = io_rdata;
    @(negedge clk); io_rd = 1'b0;
    chk(tag, {64'd0, v}, {64'd0, exp});
  endtask

  task automatic t_reset;
    chk("R1 unlocked", {71'd0, unlocked_o}, 72'd0);
    chk("R1 crt_ext", crt_ext_o, 72'd0);
    chk("R1 vse", {64'd0, vse_o}, 72'd0);
    rd_chk("R1 seq idx", 16'h03C4, 8'h00);
    rd_chk("R1 crt data", 16'h03D5, 8'h00);
    rd_chk("R1 att data", 16'h03C1, 8'h00);
  endtask

  task automatic t_locked;
    wr(16'h03D4, 8'h33); wr(16'h03D5, 8'h0F);
    rd_chk("R4 locked crt read", 16'h03D5, 8'h00);
    chk("R4 locked crt drop", crt_ext_o, 72'd0);
    wr(16'h03C4, 8'h07); wr(16'h03C5, 8'hC3);
    chk("R4 locked seq drop", {64'd0, seq_ext_o}, 72'd0);
  endtask

  task automatic t_restart;
    wr(16'h03BF, 8'h03); wr(16'h03D4, 8'h33); wr(16'h03D8, 8'hA0);
    chk("R3 other port restarts", {71'd0, unlocked_o}, 72'd0);
    wr(16'h03BF, 8'h03); wr(16'h03D8, 8'h55); wr(16'h03D8, 8'hA0);
    chk("R3 wrong value restarts", {71'd0, unlocked_o}, 72'd0);
  endtask

  task automatic t_unlock;
    wr(16'h03BF, 8'h03);
    rd_chk("R2 read between keys", 16'h03C4, 8'h07);
    wr(16'h03D8, 8'hA0);
    chk("R2 unlocked", {71'd0, unlocked_o}, 72'd1);
    rd_chk("R4 earlier crt write dropped", 16'h03D5, 8'h00);
    rd_chk("R4 earlier seq write dropped", 16'h03C5, 8'h00);
  endtask

  task automatic t_crt;
    wr(16'h03D5, 8'h0E);
    rd_chk("R6 crt 0x33", 16'h03D5, 8'h0E);
    chk("R11 start hi", {70'd0, start_hi_o}, 72'd2);
    chk("R11 cursor hi", {70'd0, cursor_hi_o}, 72'd3);
    wr(16'h03D4, 8'h3F); wr(16'h03D5, 8'h80);
    chk("R11 byte8 is 0x3F", {64'd0, crt_ext_o[71:64]}, 72'h80);
    wr(16'h03D4, 8'h30); wr(16'h03D5, 8'h5A);
    chk("R11 byte0 is 0x30", {64'd0, crt_ext_o[7:0]}, 72'h5A);
    rd_chk("R6 crt idx read", 16'h03D4, 8'h30);
    wr(16'h03D4, 8'h05); wr(16'h03D5, 8'h77);
    rd_chk("R6 crt std", 16'h03D5, 8'h77);
  endtask

  task automatic t_protect;
    wr(16'h03D4, 8'h11); wr(16'h03D5, 8'h80);
    wr(16'h03D4, 8'h35); wr(16'h03D5, 8'h12);
    rd_chk("R7 guarded read", 16'h03D5, 8'h00);
    chk("R7 guarded byte", {64'd0, crt_ext_o[47:40]}, 72'h00);
    wr(16'h03D4, 8'h11); wr(16'h03D5, 8'h00);
    wr(16'h03D4, 8'h35); wr(16'h03D5, 8'h12);
    rd_chk("R7 open read", 16'h03D5, 8'h12);
  endtask

  task automatic t_seq;
    wr(16'h03C4, 8'h07); wr(16'h03C5, 8'hC3);
    rd_chk("R5 seq ext data", 16'h03C5, 8'hC3);
    rd_chk("R5 seq idx", 16'h03C4, 8'h07);
    chk("R5 seq export", {64'd0, seq_ext_o}, 72'hC3);
    wr(16'h03C4, 8'h02); wr(16'h03C5, 8'h0F);
    rd_chk("R5 seq std", 16'h03C5, 8'h0F);
    chk("R5 seq export kept", {64'd0, seq_ext_o}, 72'hC3);
  endtask

  task automatic t_att;
    rd_chk("R9 status read zero", 16'h03DA, 8'h00);
    wr(16'h03C0, 8'h10); wr(16'h03C0, 8'h41);
    rd_chk("R8 att data", 16'h03C1, 8'h41);
    rd_chk("R8 att idx", 16'h03C0, 8'h10);
    wr(16'h03C0, 8'h16); wr(16'h03C0, 8'h80);
    chk("R8 att export", {64'd0, att_ext_o}, 72'h80);
  endtask

  task automatic t_status;
    wr(16'h03C0, 8'h05);
    rd_chk("R9 status mid toggle", 16'h03DA, 8'h00);
    wr(16'h03C0, 8'h07); wr(16'h03C0, 8'h99);
    rd_chk("R9 index after reset", 16'h03C0, 8'h07);
    rd_chk("R9 data after reset", 16'h03C1, 8'h99);
    wr(16'h03C0, 8'h05);
    rd_chk("R9 att5 untouched", 16'h03C1, 8'h00);
    rd_chk("R9 status read", 16'h03DA, 8'h00);
  endtask

  task automatic t_rdwr;
    logic [7:0] v;
    wr(16'h03C0, 8'h02);
    @(negedge clk); io_addr = 16'h03C0; io_wdata = 8'h33; io_rd = 1'b1; io_wr = 1'b1;
    #1 v = io_rdata;
    @(negedge clk); io_rd = 1'b0; io_wr = 1'b0;
    chk("R13 read sees old index", {64'd0, v}, 72'h02);
    rd_chk("R13 write landed as data", 16'h03C1, 8'h33);
    wr(16'h03C0, 8'h0A);
    rd_chk("R13 toggle back to index", 16'h03C0, 8'h0A);
    rd_chk("R13 status", 16'h03DA, 8'h00);
  endtask

  task automatic t_vse;
    wr(16'h03C3, 8'h01);
    rd_chk("R10 vse std port", 16'h03C3, 8'h01);
    chk("R10 vse export", {64'd0, vse_o}, 72'h01);
    wr(16'h03D4, 8'h34); wr(16'h03D5, 8'h08);
    chk("R10 alt select", {71'd0, vse_alt_o}, 72'd1);
    rd_chk("R10 std port hidden", 16'h03C3, 8'h00);
    rd_chk("R10 alt port read", 16'h46E8, 8'h01);
    wr(16'h46E8, 8'h09); wr(16'h03C3, 8'h00);
    chk("R10 alt write, std ignored", {64'd0, vse_o}, 72'h09);
  endtask

  task automatic t_unmapped;
    wr(16'h03D4, 8'h20); wr(16'h03D5, 8'h55);
    rd_chk("R12 crt 0x20", 16'h03D5, 8'h00);
    wr(16'h03D4, 8'h3A); wr(16'h03D5, 8'h55);
    rd_chk("R12 crt 0x3A", 16'h03D5, 8'h00);
    chk("R12 ext unchanged", crt_ext_o,
        {8'h80, 8'h00, 8'h00, 8'h12, 8'h08, 8'h0E, 8'h00, 8'h00, 8'h5A});
    wr(16'h03C4, 8'h09); wr(16'h03C5, 8'hAA);
    rd_chk("R12 seq 0x09", 16'h03C5, 8'h00);
    chk("R12 seq export kept", {64'd0, seq_ext_o}, 72'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_locked();
    t_restart();
    t_unlock();
    t_crt();
    t_protect();
    t_seq();
    t_att();
    t_status();
    t_rdwr();
    t_vse();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule